// File: doc/BRIEF.md
# Redundant Thread Commit Checker

This block sits at the retirement end of a core that runs every instruction twice, as a main copy and a redundant copy. Both copies complete on their own and report completion records tagged with a program-order sequence number. The block stores the two halves of each instruction in a pairing window. At commit it walks the oldest entries in order and retires a pair only when both halves are present and agree. A pair agrees when the operation class and the result match, and for memory operations the address matches as well.

Loads go to memory only once. The value returned for the main-thread load is pushed into a small load-value queue, and the matching redundant-thread load takes it from there. Each store retires exactly one write toward the data cache, and it uses the main thread's address and data. When a pair disagrees, the block raises a soft-exception carrying the sequence number of the faulty instruction. In the same clock it discards every pending half and the whole load-value queue. The commit point stays on the faulty instruction, so execution restarts there.

Top module: `rtc_commit_checker`

## Requirements
- R1: While reset is high and in the first cycle after it, `commit_cnt` is 0, `st_valid` is 0, `exc_valid` is 0, `m_ld_ready` is 1 and `r_ld_ready` is 0. Sequence numbering starts at 0.
- R2: A pair retires only when both halves have completed. If the oldest unretired sequence number lacks a half, nothing retires, even when younger pairs are complete.
- R3: Retirement is in program order, up to RETIRE_SLOTS/2 pairs per cycle (4 by default, since 8 retirement slots are shared by two threads). `commit_cnt` reports how many pairs retired in that cycle.
- R4: The operation class is encoded as 0 = ALU, 1 = load, 2 = store, and the result field of a store carries its data. Two halves agree when class and result are equal and, for loads and stores, the addresses are also equal. For the first disagreeing pair, `exc_valid` pulses with `exc_seq` set to its sequence number. Agreeing pairs older than it in the same cycle still retire.
- R5: A retiring store raises `st_valid` once, carrying the main half's address and data. At most one store retires per cycle. A second store stops retirement at its position until the next cycle.
- R6: The load-value queue is first-in first-out. `r_ld_value` shows the oldest held value whenever `r_ld_ready` is high, and `r_ld_pop` removes it.
- R7: `r_ld_ready` is low when the queue is empty, and a pop then has no effect. `m_ld_ready` is low when the queue holds LVQ_DEPTH values, and a push then has no effect.
- R8: In the cycle a mismatch is detected, all pending halves are discarded, including completions presented in that cycle. The load-value queue is emptied and its push and pop in that cycle are ignored. The commit point becomes the faulty sequence number.
- R9: Completions presented in one cycle can affect `commit_cnt`, `st_*` and `exc_*` no earlier than after the second following rising edge. Queue pushes and pops show on the queue ports after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_cmp_valid | input | 1 | Main-thread completion strobe |
| m_cmp_seq | input | SEQ_W | Sequence number of the main completion |
| m_cmp_kind | input | 2 | Operation class of the main completion |
| m_cmp_result | input | 32 | Main result (store data for stores) |
| m_cmp_addr | input | 32 | Main memory address |
| r_cmp_valid | input | 1 | Redundant-thread completion strobe |
| r_cmp_seq | input | SEQ_W | Sequence number of the redundant completion |
| r_cmp_kind | input | 2 | Operation class of the redundant completion |
| r_cmp_result | input | 32 | Redundant result |
| r_cmp_addr | input | 32 | Redundant memory address |
| m_ld_push | input | 1 | Main-thread load value returned from memory |
| m_ld_value | input | 32 | Returned load value |
| m_ld_ready | output | 1 | Queue can accept a value |
| r_ld_pop | input | 1 | Redundant load consumes the oldest value |
| r_ld_ready | output | 1 | Queue holds a value |
| r_ld_value | output | 32 | Oldest queued value |
| commit_cnt | output | 3 | Pairs retired this cycle |
| st_valid | output | 1 | One store released to the data cache |
| st_addr | output | 32 | Released store address |
| st_data | output | 32 | Released store data |
| exc_valid | output | 1 | Soft-exception pulse |
| exc_seq | output | SEQ_W | Sequence number of the faulty instruction |

## Verification
A completion written at edge t is part of the window from then on. The commit decision is formed from the window during the next cycle and registered at edge t+1, so `commit_cnt`, `st_*` and `exc_*` move two edges after the stimulus was presented. The queue ports are combinational views of state that changes at the next edge. The bench drives inputs at the falling edge and advances a behavioural model at each rising edge using the values it drove. It then compares every output at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    parameter int RTC_DATA_W = 32;
    parameter int RTC_ADDR_W = 32;

    typedef enum logic [1:0] {
        OPK_ALU   = 2'd0,
        OPK_LOAD  = 2'd1,
        OPK_STORE = 2'd2,
        OPK_RSVD  = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e                kind;
        logic [RTC_DATA_W-1:0]   result;
        logic [RTC_ADDR_W-1:0]   addr;
    } half_rec_t;

    function automatic logic halves_agree(input half_rec_t a, input half_rec_t b);
        logic same;
        same = (a.kind == b.kind) && (a.result == b.result);
        if (a.kind == OPK_LOAD || a.kind == OPK_STORE)
            same = same && (a.addr == b.addr);
        return same;
    endfunction

endpackage

// File: rtl/rtc_lvq.sv
module rtc_lvq #(
    parameter int DEPTH = 4,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    output logic          push_ready,
    input  logic          pop,
    output logic          pop_ready,
    output logic [DW-1:0] pop_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] store_q [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ready = (fill != CW'(DEPTH));
    assign pop_ready  = (fill != '0);
    assign pop_data   = store_q[rd_ptr];
    assign do_push    = push && push_ready && !flush;
    assign do_pop     = pop && pop_ready && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                store_q[wr_ptr] <= push_data;
                wr_ptr          <= bump(wr_ptr);
            end
            if (do_pop)
                rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !pop_ready);
    p_full_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (push && !push_ready && !pop && !flush) |=> (fill == $past(fill)));
    p_empty_pop_r7: assert property (@(posedge clk) disable iff (rst)
        (pop && !pop_ready && !push && !flush) |=> !pop_ready);

endmodule

// File: rtl/rtc_pair_window.sv
module rtc_pair_window
    import rtc_pkg::*;
#(
    parameter int WIN   = 16,
    parameter int SEQ_W = 8,
    parameter int LANES = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            flush,
    input  logic                            m_wr_en,
    input  logic [SEQ_W-1:0]                m_wr_seq,
    input  half_rec_t                       m_wr_rec,
    input  logic                            r_wr_en,
    input  logic [SEQ_W-1:0]                r_wr_seq,
    input  half_rec_t                       r_wr_rec,
    input  logic [$clog2(LANES+1)-1:0]      retire_cnt,
    output logic [SEQ_W-1:0]                head_seq,
    output logic [LANES-1:0]                lane_m_vld,
    output logic [LANES-1:0]                lane_r_vld,
    output half_rec_t                       lane_m_rec [LANES],
    output half_rec_t                       lane_r_rec [LANES]
);
    localparam int IDX_W = $clog2(WIN);
    localparam int CNT_W = $clog2(LANES + 1);

    logic [WIN-1:0]   m_vld, r_vld;
    half_rec_t        m_rec [WIN];
    half_rec_t        r_rec [WIN];
    logic [IDX_W-1:0] head_idx;

    assign head_idx = head_seq[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)
            head_seq <= '0;
        else
            head_seq <= head_seq + SEQ_W'(retire_cnt);
    end

    for (genvar j = 0; j < WIN; j++) begin : g_slot
        logic [IDX_W-1:0] age;
        logic             leaving;
        logic             m_hit, r_hit;

        assign age     = IDX_W'(j) - head_idx;
        assign leaving = ({{(IDX_W > CNT_W ? IDX_W - CNT_W : 0){1'b0}}, age} < IDX_W'(retire_cnt));
        assign m_hit   = m_wr_en && (m_wr_seq[IDX_W-1:0] == IDX_W'(j));
        assign r_hit   = r_wr_en && (r_wr_seq[IDX_W-1:0] == IDX_W'(j));

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                m_vld[j] <= 1'b0;
                r_vld[j] <= 1'b0;
            end else begin
                if (m_hit)        m_vld[j] <= 1'b1;
                else if (leaving) m_vld[j] <= 1'b0;
                if (r_hit)        r_vld[j] <= 1'b1;
                else if (leaving) r_vld[j] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (m_hit) m_rec[j] <= m_wr_rec;
            if (r_hit) r_rec[j] <= r_wr_rec;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [IDX_W-1:0] at;
        assign at            = head_idx + IDX_W'(i);
        assign lane_m_vld[i] = m_vld[at];
        assign lane_r_vld[i] = r_vld[at];
        assign lane_m_rec[i] = m_rec[at];
        assign lane_r_rec[i] = r_rec[at];
    end

    p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (lane_m_vld == '0 && lane_r_vld == '0));

endmodule

// File: rtl/rtc_commit_select.sv
module rtc_commit_select
    import rtc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [LANES-1:0]                  lane_m_vld,
    input  logic [LANES-1:0]                  lane_r_vld,
    input  half_rec_t                         lane_m_rec [LANES],
    input  half_rec_t                         lane_r_rec [LANES],
    output logic [$clog2(LANES+1)-1:0]        retire_cnt,
    output logic                              st_fire,
    output half_rec_t                         st_rec,
    output logic                              exc_fire,
    output logic [(LANES>1?$clog2(LANES):1)-1:0] exc_lane
);
    localparam int CNT_W  = $clog2(LANES + 1);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LANES-1:0] st_lane;

    always_comb begin
        logic blocked;
        blocked    = 1'b0;
        retire_cnt = '0;
        st_fire    = 1'b0;
        st_rec     = '0;
        exc_fire   = 1'b0;
        exc_lane   = '0;
        st_lane    = '0;
        for (int i = 0; i < LANES; i++) begin
            if (!blocked) begin
                if (!(lane_m_vld[i] && lane_r_vld[i])) begin
                    blocked = 1'b1;
                end else if (!halves_agree(lane_m_rec[i], lane_r_rec[i])) begin
                    exc_fire = 1'b1;
                    exc_lane = LANE_W'(i);
                    blocked  = 1'b1;
                end else if (lane_m_rec[i].kind == OPK_STORE && st_fire) begin
                    blocked = 1'b1;
                end else begin
                    retire_cnt = retire_cnt + CNT_W'(1);
                    if (lane_m_rec[i].kind == OPK_STORE) begin
                        st_fire    = 1'b1;
                        st_rec     = lane_m_rec[i];
                        st_lane[i] = 1'b1;
                    end
                end
            end
        end
    end

    p_single_store_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(st_lane));

endmodule

// File: rtl/rtc_commit_checker.sv
module rtc_commit_checker
    import rtc_pkg::*;
#(
    parameter int SEQ_W        = 8,
    parameter int WIN          = 16,
    parameter int LVQ_DEPTH    = 4,
    parameter int RETIRE_SLOTS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        m_cmp_valid,
    input  logic [SEQ_W-1:0]            m_cmp_seq,
    input  logic [1:0]                  m_cmp_kind,
    input  logic [RTC_DATA_W-1:0]       m_cmp_result,
    input  logic [RTC_ADDR_W-1:0]       m_cmp_addr,
    input  logic                        r_cmp_valid,
    input  logic [SEQ_W-1:0]            r_cmp_seq,
    input  logic [1:0]                  r_cmp_kind,
    input  logic [RTC_DATA_W-1:0]       r_cmp_result,
    input  logic [RTC_ADDR_W-1:0]       r_cmp_addr,
    input  logic                        m_ld_push,
    input  logic [RTC_DATA_W-1:0]       m_ld_value,
    output logic                        m_ld_ready,
    input  logic                        r_ld_pop,
    output logic                        r_ld_ready,
    output logic [RTC_DATA_W-1:0]       r_ld_value,
    output logic [$clog2(RETIRE_SLOTS/2+1)-1:0] commit_cnt,
    output logic                        st_valid,
    output logic [RTC_ADDR_W-1:0]       st_addr,
    output logic [RTC_DATA_W-1:0]       st_data,
    output logic                        exc_valid,
    output logic [SEQ_W-1:0]            exc_seq
);
    localparam int LANES  = RETIRE_SLOTS / 2;
    localparam int CNT_W  = $clog2(LANES + 1);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    half_rec_t              m_in, r_in;
    logic [SEQ_W-1:0]       head_seq;
    logic [LANES-1:0]       lane_m_vld, lane_r_vld;
    half_rec_t              lane_m_rec [LANES];
    half_rec_t              lane_r_rec [LANES];
    logic [CNT_W-1:0]       retire_cnt;
    logic                   st_fire, exc_fire;
    half_rec_t              st_rec;
    logic [LANE_W-1:0]      exc_lane;

    assign m_in = '{kind: op_kind_e'(m_cmp_kind), result: m_cmp_result, addr: m_cmp_addr};
    assign r_in = '{kind: op_kind_e'(r_cmp_kind), result: r_cmp_result, addr: r_cmp_addr};

    rtc_lvq #(.DEPTH(LVQ_DEPTH), .DW(RTC_DATA_W)) u_lvq (
        .clk(clk), .rst(rst), .flush(exc_fire),
        .push(m_ld_push), .push_data(m_ld_value), .push_ready(m_ld_ready),
        .pop(r_ld_pop), .pop_ready(r_ld_ready), .pop_data(r_ld_value)
    );

    rtc_pair_window #(.WIN(WIN), .SEQ_W(SEQ_W), .LANES(LANES)) u_window (
        .clk(clk), .rst(rst), .flush(exc_fire),
        .m_wr_en(m_cmp_valid), .m_wr_seq(m_cmp_seq), .m_wr_rec(m_in),
        .r_wr_en(r_cmp_valid), .r_wr_seq(r_cmp_seq), .r_wr_rec(r_in),
        .retire_cnt(retire_cnt), .head_seq(head_seq),
        .lane_m_vld(lane_m_vld), .lane_r_vld(lane_r_vld),
        .lane_m_rec(lane_m_rec), .lane_r_rec(lane_r_rec)
    );

    rtc_commit_select #(.LANES(LANES)) u_select (
        .clk(clk), .rst(rst),
        .lane_m_vld(lane_m_vld), .lane_r_vld(lane_r_vld),
        .lane_m_rec(lane_m_rec), .lane_r_rec(lane_r_rec),
        .retire_cnt(retire_cnt), .st_fire(st_fire), .st_rec(st_rec),
        .exc_fire(exc_fire), .exc_lane(exc_lane)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_cnt <= '0;
            st_valid   <= 1'b0;
            st_addr    <= '0;
            st_data    <= '0;
            exc_valid  <= 1'b0;
            exc_seq    <= '0;
        end else begin
            commit_cnt <= retire_cnt;
            st_valid   <= st_fire;
            st_addr    <= st_rec.addr;
            st_data    <= st_rec.result;
            exc_valid  <= exc_fire;
            exc_seq    <= head_seq + SEQ_W'(exc_lane);
        end
    end

    p_exc_then_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (commit_cnt == '0 && !exc_valid && !st_valid));
    p_store_needs_commit_r5: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (commit_cnt != '0));
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        commit_cnt <= CNT_W'(LANES));

endmodule

// File: tb/rtc_commit_checker_test.sv
module rtc_commit_checker_test;
    localparam int SEQ_W = 8;
    localparam int DEPTH = 4;
    localparam int LANES = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_cmp_valid = 0, r_cmp_valid = 0;
    logic [SEQ_W-1:0] m_cmp_seq = 0, r_cmp_seq = 0;
    logic [1:0] m_cmp_kind = 0, r_cmp_kind = 0;
    logic [31:0] m_cmp_result = 0, r_cmp_result = 0, m_cmp_addr = 0, r_cmp_addr = 0;
    logic m_ld_push = 0, r_ld_pop = 0;
    logic [31:0] m_ld_value = 0;
    logic m_ld_ready, r_ld_ready, st_valid, exc_valid;
    logic [31:0] r_ld_value, st_addr, st_data;
    logic [2:0] commit_cnt;
    logic [SEQ_W-1:0] exc_seq;

    always #10 clk = ~clk;

    rtc_commit_checker uut (
        .clk(clk), .rst(rst),
        .m_cmp_valid(m_cmp_valid), .m_cmp_seq(m_cmp_seq), .m_cmp_kind(m_cmp_kind),
        .m_cmp_result(m_cmp_result), .m_cmp_addr(m_cmp_addr),
        .r_cmp_valid(r_cmp_valid), .r_cmp_seq(r_cmp_seq), .r_cmp_kind(r_cmp_kind),
        .r_cmp_result(r_cmp_result), .r_cmp_addr(r_cmp_addr),
        .m_ld_push(m_ld_push), .m_ld_value(m_ld_value), .m_ld_ready(m_ld_ready),
        .r_ld_pop(r_ld_pop), .r_ld_ready(r_ld_ready), .r_ld_value(r_ld_value),
        .commit_cnt(commit_cnt), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .exc_valid(exc_valid), .exc_seq(exc_seq)
    );

    int total = 0;
    int bad = 0;
    string cur = "R1";

    // behavioural reference state, indexed by sequence number modulo 256
    bit mv[256], rv[256];
    int mk[256], rk[256];
    logic [31:0] mres[256], rres[256], madr[256], radr[256];
    int head = 0;
    logic [31:0] lvq[$];
    int e_cnt = 0, e_exc_seq = 0;
    bit e_st = 0, e_exc = 0;
    logic [31:0] e_st_addr = 0, e_st_data = 0;

    task automatic chk(input string what, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d t=%0t", cur, what, got, exp, $time);
        end
    endtask

    function automatic bit agree(input int s);
        bit ok;
        ok = (mk[s] == rk[s]) && (mres[s] == rres[s]);
        if (mk[s] == 1 || mk[s] == 2) ok = ok && (madr[s] == radr[s]);
        return ok;
    endfunction

    task automatic model_step();
        if (rst) begin
            foreach (mv[i]) begin mv[i] = 0; rv[i] = 0; end
            head = 0; lvq.delete();
            e_cnt = 0; e_st = 0; e_exc = 0;
            return;
        end
        e_cnt = 0; e_st = 0; e_exc = 0;
        for (int i = 0; i < LANES; i++) begin
            int s;
            s = (head + i) % 256;
            if (!(mv[s] && rv[s])) break;
            if (!agree(s)) begin e_exc = 1; e_exc_seq = s; break; end
            if (mk[s] == 2) begin
                if (e_st) break;
                e_st = 1; e_st_addr = madr[s]; e_st_data = mres[s];
            end
            e_cnt++;
        end
        for (int i = 0; i < e_cnt; i++) begin
            mv[(head + i) % 256] = 0; rv[(head + i) % 256] = 0;
        end
        head = (head + e_cnt) % 256;
        if (e_exc) begin
            foreach (mv[i]) begin mv[i] = 0; rv[i] = 0; end
            lvq.delete();
            return;
        end
        if (m_cmp_valid) begin
            mv[m_cmp_seq] = 1; mk[m_cmp_seq] = m_cmp_kind;
            mres[m_cmp_seq] = m_cmp_result; madr[m_cmp_seq] = m_cmp_addr;
        end
        if (r_cmp_valid) begin
            rv[r_cmp_seq] = 1; rk[r_cmp_seq] = r_cmp_kind;
            rres[r_cmp_seq] = r_cmp_result; radr[r_cmp_seq] = r_cmp_addr;
        end
        begin
            bit can_pop, can_push;
            can_pop  = r_ld_pop && lvq.size() > 0;
            can_push = m_ld_push && lvq.size() < DEPTH;
            if (can_pop) void'(lvq.pop_front());
            if (can_push) lvq.push_back(m_ld_value);
        end
    endtask

    // R9: registered results are compared one half cycle after the edge that loads them
    task automatic compare();
        chk("commit_cnt", commit_cnt, e_cnt);
        chk("st_valid", st_valid, e_st);
        if (e_st) begin
            chk("st_addr", st_addr, e_st_addr);
            chk("st_data", st_data, e_st_data);
        end
        chk("exc_valid", exc_valid, e_exc);
        if (e_exc) chk("exc_seq", exc_seq, e_exc_seq);
        chk("m_ld_ready", m_ld_ready, lvq.size() < DEPTH);
        chk("r_ld_ready", r_ld_ready, lvq.size() > 0);
        if (lvq.size() > 0) chk("r_ld_value", r_ld_value, lvq[0]);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        m_cmp_valid = 0; r_cmp_valid = 0; m_ld_push = 0; r_ld_pop = 0;
    endtask

    task automatic setm(input int s, input int k, input int res, input int adr);
        m_cmp_valid = 1; m_cmp_seq = SEQ_W'(s); m_cmp_kind = 2'(k);
        m_cmp_result = res; m_cmp_addr = adr;
    endtask

    task automatic setr(input int s, input int k, input int res, input int adr);
        r_cmp_valid = 1; r_cmp_seq = SEQ_W'(s); r_cmp_kind = 2'(k);
        r_cmp_result = res; r_cmp_addr = adr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        cur = "R1";
        idle(2);
        rst = 0;
        idle(1);

        // R2: seq 0 lacks its redundant half, younger complete pairs wait
        cur = "R2";
        for (int s = 0; s < 4; s++) begin setm(s, 0, 100 + s, 0); tick(); end
        for (int s = 1; s < 4; s++) begin setr(s, 0, 100 + s, 0); tick(); end
        idle(2);
        setr(0, 0, 100, 0); tick();
        idle(2);

        // R3: six ready pairs retire as four then two
        cur = "R3";
        for (int s = 4; s < 10; s++) begin setm(s, 0, 200 + s, 0); tick(); end
        for (int s = 9; s >= 4; s--) begin setr(s, 0, 200 + s, 0); tick(); end
        idle(3);

        // R5: stores 10,11,13 and ALU 12 -> one store per cycle
        cur = "R5";
        setm(10, 2, 'h1111, 'h4000); tick();
        setm(11, 2, 'h2222, 'h4004); tick();
        setm(12, 0, 'h3333, 0);      tick();
        setm(13, 2, 'h4444, 'h4008); tick();
        setr(13, 2, 'h4444, 'h4008); tick();
        setr(12, 0, 'h3333, 0);      tick();
        setr(11, 2, 'h2222, 'h4004); tick();
        setr(10, 2, 'h1111, 'h4000); tick();
        idle(4);

        // R6: FIFO order of returned load values
        cur = "R6";
        for (int i = 0; i < 3; i++) begin m_ld_push = 1; m_ld_value = 'hA0 + i; tick(); end
        r_ld_pop = 1; m_ld_push = 1; m_ld_value = 'hB0; tick();
        r_ld_pop = 1; tick();

        // R7: overfill and empty pop are ignored
        cur = "R7";
        for (int i = 0; i < 4; i++) begin m_ld_push = 1; m_ld_value = 'hC0 + i; tick(); end
        for (int i = 0; i < 5; i++) begin r_ld_pop = 1; tick(); end
        r_ld_pop = 1; tick();
        m_ld_push = 1; m_ld_value = 'hD0; tick();
        m_ld_push = 1; m_ld_value = 'hD1; tick();

        // R4 and R8: load address mismatch at 15, 14 retires alongside
        cur = "R4";
        setm(14, 1, 'h55, 'h800); tick();
        setm(15, 1, 'h66, 'h900); tick();
        setm(16, 0, 'h77, 0);     tick();
        setr(16, 0, 'h77, 0);     tick();
        setr(15, 1, 'h66, 'h904); tick();
        setr(14, 1, 'h55, 'h800); tick();
        cur = "R8";
        setm(16, 0, 'h77, 0); setr(16, 0, 'h77, 0);
        m_ld_push = 1; m_ld_value = 'hEE; tick();
        idle(2);
        setm(15, 1, 'h66, 'h900); setr(15, 1, 'h66, 'h900); tick();
        idle(2);
        setm(16, 0, 'h77, 0); setr(16, 0, 'h77, 0); tick();
        idle(2);

        // R4: result mismatch, kind mismatch, store address mismatch
        cur = "R4";
        setm(17, 0, 'h1, 0); setr(17, 0, 'h2, 0); tick();
        idle(2);
        setm(17, 0, 'h1, 0); setr(17, 1, 'h1, 0); tick();
        idle(2);
        setm(17, 0, 'h1, 0); setr(17, 0, 'h1, 'hFF); tick();
        idle(2);
        setm(18, 2, 'h9, 'h100); setr(18, 2, 'h9, 'h104); tick();
        idle(2);
        setm(18, 2, 'h9, 'h100); setr(18, 2, 'h9, 'h100); tick();
        idle(3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule